// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a software watchdog that sits on a simple 32-bit register bus. Reads and writes each take a single cycle. Software sets a 16-bit reload count, picks the expiry action and picks the tick rate. It then sets the enable bit, and from that point a down-counter drains towards expiry. To keep the system alive, software writes a two-value key to the service location in the correct order. Each correct key pair restarts the countdown from the programmed count.

The enable bit can be written only once after reset. The first write to the control register fixes the enable state for good. A running watchdog therefore cannot be stopped, and a watchdog left off cannot be started later. On expiry the block does one of two things, chosen by a mode bit:
- it drives a one-cycle pulse to the reset controller, or
- it raises a sticky interrupt that stays high until the next valid service.

The tick is either every clock or one per `PRESCALE_DIV` clocks. The default divider is 65536, and a 2048-clock build is one parameter change away. The timeout in seconds is the reload count × the divider ÷ the clock frequency.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the control word reads 0xFFFF0003 (count 0xFFFF, disabled, reset mode, prescaler on), the count register reads 0x0000FFFF, and `wd_reset_o` and `wd_irq_o` are low.
- R2: The control word at byte offset 0x04 holds the reload count in bits 31:16, enable in bit 2, the expiry select in bit 1 (1 = reset, 0 = interrupt) and the prescale enable in bit 1's neighbour, bit 0. A write whose count field is zero leaves the stored count unchanged; the other fields still take the written value.
- R3: The first control write after reset sets the enable bit and locks it. Later writes cannot change bit 2.
- R4: While enabled, the counter drops by one per tick. The tick is every clock when bit 0 is 0, and every `PRESCALE_DIV` clocks when bit 0 is 1, the first tick falling `PRESCALE_DIV` clocks after enable or service. Offset 0x08 reads the live count in bits 15:0. Writes to 0x08 have no effect.
- R5: A tick that finds the count at 1 is an expiry. The counter reloads from the stored count, so the count never reads zero. In reset mode `wd_reset_o` is high for exactly the following cycle.
- R6: An expiry in interrupt mode sets `wd_irq_o`. It stays set until a valid service.
- R7: Writing 0x556C and then 0xAA39 to the service location (offset 0x0C or 0x0E, data in bits 15:0) is a valid service. It reloads the counter on the edge of the second write, restarts the prescaler and clears `wd_irq_o`.
- R8: Any other value written to the service location clears the key tracker without a reload, and so does 0xAA39 written without a directly preceding 0x556C. Writes to other offsets leave the tracker as it is.
- R9: Reads of offsets 0x00, 0x0C, 0x0E or any unmapped offset return zero.
- R10: While disabled, the count register follows the stored reload count and neither output is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| wd_reset_o | output | 1 | One-cycle expiry pulse in reset mode |
| wd_irq_o | output | 1 | Sticky expiry interrupt in interrupt mode |

## Verification
Reads are combinational, so a register value can be checked in the same cycle the address is driven. A write takes effect at the clock edge that samples it, so the count reads the new reload value right after the enabling or second-key edge. After that edge, with the prescaler off, the count reads reload − n after n more edges, and the expiry output is high after exactly reload edges. With the prescaler on, the first drop comes `PRESCALE_DIV` edges after enable. The bench keeps a running tally of edges since each load and samples 1 ns after the edge, comparing against reload minus that tally.

// File: rtl/wdt_keyed_pkg.sv
// Package: shared register offsets, service keys and control-word layout
// for the keyed-service watchdog. Assumes a 32-bit data bus and byte offsets.
package wdt_keyed_pkg;

    localparam int          DATA_W     = 32;
    localparam int          ADDR_W     = 8;
    localparam int          CNT_W      = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SVC_W  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SVC_H  = 8'h0E;

    localparam logic [15:0] KEY_FIRST  = 16'h556C;
    localparam logic [15:0] KEY_SECOND = 16'hAA39;

    localparam int          TC_LSB     = 16;
    localparam int          BIT_EN     = 2;
    localparam int          BIT_MODE   = 1;
    localparam int          BIT_PRE    = 0;

    localparam logic [CNT_W-1:0] TC_RESET = '1;

    typedef struct packed {
        logic [CNT_W-1:0] tc;
        logic             en;
        logic             rst_mode;
        logic             pre_on;
    } wdt_ctrl_t;

endpackage

// File: rtl/wdt_ctrl_reg.sv
// Control register: holds reload count, enable, expiry select and prescale
// enable. Enable is write-once after reset; a zero count field is refused.
// Assumes wr_ctrl is a single-cycle strobe from the bus decoder.
module wdt_ctrl_reg
    import wdt_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output wdt_ctrl_t         ctrl_q,
    output logic [CNT_W-1:0]  tc_load,
    output logic              en_locked
);

    logic [CNT_W-1:0] wr_tc;
    logic             wr_tc_ok;

    // Decode the count field of the incoming write.
    always_comb begin
        wr_tc    = wdata[TC_LSB +: CNT_W];
        wr_tc_ok = wr_ctrl && (wr_tc != '0);
        tc_load  = wr_tc_ok ? wr_tc : ctrl_q.tc;
    end

    // Register update with write-once enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.tc       <= TC_RESET;
            ctrl_q.en       <= 1'b0;
            ctrl_q.rst_mode <= 1'b1;
            ctrl_q.pre_on   <= 1'b1;
            en_locked       <= 1'b0;
        end else if (wr_ctrl) begin
            if (wr_tc_ok) begin
                ctrl_q.tc <= wr_tc;
            end
            ctrl_q.rst_mode <= wdata[BIT_MODE];
            ctrl_q.pre_on   <= wdata[BIT_PRE];
            if (!en_locked) begin
                ctrl_q.en <= wdata[BIT_EN];
                en_locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_key_seq.sv
// Service key tracker: recognises the ordered two-word key. Any write that
// is not the first key disarms it. Assumes svc_wr is a single-cycle strobe.
module wdt_key_seq
    import wdt_keyed_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_data,
    output logic        svc_ok
);

    logic armed_q;

    // Valid service: second key while armed by the first.
    always_comb begin
        svc_ok = svc_wr && armed_q && (svc_data == KEY_SECOND);
    end

    // Arm on the first key, disarm on anything else written here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (svc_wr) begin
            armed_q <= (svc_data == KEY_FIRST);
        end
    end

endmodule

// File: rtl/wdt_tick_gen.sv
// Tick generator: a tick every clock, or one per DIV clocks when the
// prescaler is on. Restarts from zero when stopped or on restart.
// Assumes DIV >= 1.
module wdt_tick_gen #(
    parameter int DIV = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pre_on,
    input  logic restart,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_nodiv
            // A divider of one is the same as no prescaler.
            always_comb begin
                tick = run;
            end
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pcnt_q;

            // Tick on the last phase of the prescaler.
            always_comb begin
                tick = run && (!pre_on || (pcnt_q == LAST));
            end

            // Phase counter, cleared when idle or restarted.
            always_ff @(posedge clk) begin
                if (!rst_n || !run || restart || !pre_on) begin
                    pcnt_q <= '0;
                end else if (pcnt_q == LAST) begin
                    pcnt_q <= '0;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdt_down_counter.sv
// Down-counter and expiry logic: follows the reload value while stopped,
// decrements per tick while running, and on expiry reloads and raises
// the reset pulse or the sticky interrupt. A service wins over an expiry.
module wdt_down_counter
    import wdt_keyed_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic             rst_mode,
    input  logic [CNT_W-1:0] tc_load,
    output logic [CNT_W-1:0] count_q,
    output logic             wd_reset_o,
    output logic             wd_irq_o
);

    logic expire;

    // Expiry: a tick that finds the count at one.
    always_comb begin
        expire = run && tick && !reload && (count_q == CNT_W'(1));
    end

    // Count, pulse and sticky interrupt update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= TC_RESET;
            wd_reset_o <= 1'b0;
            wd_irq_o   <= 1'b0;
        end else begin
            wd_reset_o <= expire && rst_mode;
            if (!run) begin
                count_q <= tc_load;
            end else if (reload) begin
                count_q  <= tc_load;
                wd_irq_o <= 1'b0;
            end else if (expire) begin
                count_q <= tc_load;
                if (!rst_mode) begin
                    wd_irq_o <= 1'b1;
                end
            end else if (tick) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_keyed_top.sv
// Keyed-service watchdog top: decodes single-cycle bus accesses, and ties
// together the control register, key tracker, tick generator and
// down-counter. Read data is combinational from the address.
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int PRESCALE_DIV = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_reset_o,
    output logic              wd_irq_o
);

    logic             wr_ctrl;
    logic             svc_wr;
    logic             svc_ok;
    logic             tick;
    logic             en_locked;
    wdt_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] tc_load;
    logic [CNT_W-1:0] count_q;

    // Write strobes for the control and service locations.
    always_comb begin
        wr_ctrl = bus_sel && bus_we && (bus_addr == OFS_CTRL);
        svc_wr  = bus_sel && bus_we &&
                  ((bus_addr == OFS_SVC_W) || (bus_addr == OFS_SVC_H));
    end

    // Read mux; everything but control and count reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_CTRL:  bus_rdata = {ctrl_q.tc, 13'd0, ctrl_q.en,
                                        ctrl_q.rst_mode, ctrl_q.pre_on};
                OFS_COUNT: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, count_q};
                default:   bus_rdata = '0;
            endcase
        end
    end

    wdt_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata),
        .ctrl_q    (ctrl_q),
        .tc_load   (tc_load),
        .en_locked (en_locked)
    );

    wdt_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (bus_wdata[15:0]),
        .svc_ok   (svc_ok)
    );

    wdt_tick_gen #(.DIV(PRESCALE_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.en),
        .pre_on  (ctrl_q.pre_on),
        .restart (svc_ok),
        .tick    (tick)
    );

    wdt_down_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q.en),
        .tick       (tick),
        .reload     (svc_ok),
        .rst_mode   (ctrl_q.rst_mode),
        .tc_load    (tc_load),
        .count_q    (count_q),
        .wd_reset_o (wd_reset_o),
        .wd_irq_o   (wd_irq_o)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
// Checker for the keyed-service watchdog, bound into the top module.
// Relates control state, tick, service and outputs across cycles.
module wdt_keyed_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        locked,
    input logic        rst_mode,
    input logic [15:0] tc_q,
    input logic [15:0] count_q,
    input logic        tick,
    input logic        svc_ok,
    input logic        wd_reset_o,
    input logic        wd_irq_o
);

    AST_TC_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) tc_q != 16'h0); // R2
    AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(en)); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (en && !tick && !svc_ok) |=> $stable(count_q)); // R4
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) count_q != 16'h0); // R5
    AST_PULSE_IN_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n) wd_reset_o |-> $past(rst_mode)); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (wd_irq_o && !svc_ok) |=> wd_irq_o); // R6
    AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) svc_ok |=> (!wd_irq_o && !wd_reset_o)); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |-> (!wd_reset_o && !wd_irq_o)); // R10

endmodule

bind wdt_keyed_top wdt_keyed_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctrl_q.en),
    .locked     (en_locked),
    .rst_mode   (ctrl_q.rst_mode),
    .tc_q       (ctrl_q.tc),
    .count_q    (count_q),
    .tick       (tick),
    .svc_ok     (svc_ok),
    .wd_reset_o (wd_reset_o),
    .wd_irq_o   (wd_irq_o)
);

// File: tb/tb_wdt_keyed_top.sv
`timescale 1ns/1ps
module tb_wdt_keyed_top;

    localparam int DIV = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_reset_o;
    logic        wd_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wdt_keyed_top #(.PRESCALE_DIV(DIV)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wd_reset_o (wd_reset_o),
        .wd_irq_o   (wd_irq_o)
    );

    function automatic logic [31:0] ctrl_word(int tc, bit en, bit rmode, bit pre);
        return {tc[15:0], 13'd0, en, rmode, pre};
    endfunction

    function automatic logic [31:0] exp_count(int tc, int edges);
        return 32'(tc - edges);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int unsigned sd;
        sd = $urandom(32'd20240611);
        #1;

        // R1 reset state and R9 unmapped reads
        do_reset();
        rd(8'h04, d); chk("R1 ctrl", d, 32'hFFFF0003);
        rd(8'h08, d); chk("R1 count", d, 32'h0000FFFF);
        chk("R1 outputs", {30'd0, wd_reset_o, wd_irq_o}, 32'd0);
        rd(8'h00, d); chk("R9 offset 0x00", d, 32'd0);
        rd(8'h0C, d); chk("R9 offset 0x0C", d, 32'd0);
        step(1);
        rd(8'h10, d); chk("R9 offset 0x10", d, 32'd0);

        // R2 zero count field refused, other fields taken
        do_reset();
        wr(8'h04, ctrl_word(0, 1, 0, 0));
        rd(8'h04, d); chk("R2 zero tc", d, 32'hFFFF0004);
        rd(8'h08, d); chk("R2 count kept", d, 32'h0000FFFF);

        // R3 enabled then disable attempt
        do_reset();
        wr(8'h04, ctrl_word(50, 1, 1, 0));
        wr(8'h04, ctrl_word(50, 0, 1, 0));
        rd(8'h04, d); chk("R3 en stays set", d, ctrl_word(50, 1, 1, 0));
        rd(8'h08, d); chk("R3 still counting", d, exp_count(50, 1));

        // R3/R10 disabled first then enable attempt
        do_reset();
        wr(8'h04, ctrl_word(5, 0, 0, 0));
        wr(8'h04, ctrl_word(5, 1, 0, 0));
        rd(8'h04, d); chk("R3 en stays clear", d, ctrl_word(5, 0, 0, 0));
        step(20);
        rd(8'h08, d); chk("R10 count frozen at tc", d, 32'd5);
        chk("R10 no outputs", {30'd0, wd_reset_o, wd_irq_o}, 32'd0);
        wr(8'h04, ctrl_word(7, 0, 0, 0));
        rd(8'h08, d); chk("R10 count follows tc", d, 32'd7);

        // R6/R7 interrupt mode
        do_reset();
        wr(8'h04, ctrl_word(4, 1, 0, 0));
        step(3);
        chk("R6 irq before expiry", {31'd0, wd_irq_o}, 32'd0);
        step(1);
        chk("R6 irq at expiry", {31'd0, wd_irq_o}, 32'd1);
        chk("R6 no reset pulse", {31'd0, wd_reset_o}, 32'd0);
        rd(8'h08, d); chk("R5 reload on expiry", d, 32'd4);
        step(9);
        chk("R6 irq sticky", {31'd0, wd_irq_o}, 32'd1);
        wr(8'h0C, 32'h0000556C);
        wr(8'h0C, 32'h0000AA39);
        chk("R7 irq cleared", {31'd0, wd_irq_o}, 32'd0);
        rd(8'h08, d); chk("R7 reload", d, 32'd4);

        // R8 broken sequences, R4 count write ignored, R7 halfword offset
        do_reset();
        wr(8'h04, ctrl_word(40, 1, 0, 0));
        wr(8'h0C, 32'h0000AA39);
        rd(8'h08, d); chk("R8 lone second key", d, exp_count(40, 1));
        wr(8'h0C, 32'h00001234);
        wr(8'h0C, 32'h0000AA39);
        rd(8'h08, d); chk("R8 wrong then second key", d, exp_count(40, 3));
        wr(8'h0C, 32'h0000556C);
        wr(8'h0C, 32'h0000AA38);
        wr(8'h0C, 32'h0000AA39);
        rd(8'h08, d); chk("R8 key broken in middle", d, exp_count(40, 6));
        wr(8'h08, 32'h00000001);
        rd(8'h08, d); chk("R4 count write ignored", d, exp_count(40, 7));
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h0000AA39);
        rd(8'h08, d); chk("R7 service at 0x0E", d, 32'd40);

        // R4/R5 prescaled ticks, reset mode
        do_reset();
        wr(8'h04, ctrl_word(3, 1, 1, 1));
        step(DIV - 1);
        rd(8'h08, d); chk("R4 no tick before DIV", d, 32'd3);
        step(1);
        rd(8'h08, d); chk("R4 tick at DIV", d, 32'd2);
        step(2 * DIV - 1);
        chk("R5 no pulse early", {31'd0, wd_reset_o}, 32'd0);
        step(1);
        chk("R5 pulse at prescaled expiry", {31'd0, wd_reset_o}, 32'd1);

        // Random reset-mode runs with service
        for (int i = 0; i < 12; i++) begin
            int t;
            int n;
            t = 4 + int'($urandom % 40);
            n = int'($urandom % (t - 3));
            do_reset();
            wr(8'h04, ctrl_word(t, 1, 1, 0));
            step(n);
            rd(8'h08, d); chk("R4 random drain", d, exp_count(t, n));
            wr(8'h0C, 32'h0000556C);
            wr(8'h0C, 32'h0000AA39);
            rd(8'h08, d); chk("R7 random service", d, exp_count(t, 0));
            step(t - 1);
            chk("R5 random no early pulse", {31'd0, wd_reset_o}, 32'd0);
            step(1);
            chk("R5 random pulse", {31'd0, wd_reset_o}, 32'd1);
            step(1);
            chk("R5 pulse one cycle", {31'd0, wd_reset_o}, 32'd0);
        end

        finish_run();
    end

endmodule